// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescing Controller

This block keeps a two-bit state for each source in a bank of interrupt sources and uses it to decide when a trigger becomes a notification to a downstream event queue. Bit P records that the source has been forwarded and is waiting for an end-of-interrupt (EOI). Bit Q records that another trigger arrived while P was set. Because of these two bits, repeated triggers are merged, and a source has at most one outstanding queue entry at any time.

Software controls each source through its own 4 KiB page on a simple register bus. The bus address is split into a source index in the upper bits and a 12-bit page offset in the lower bits. Every control access is a 64-bit load. The load returns the state as it was before the access, and the same clock edge applies the new state. One offset reads the state. Four offsets force it to a chosen value. One offset performs an EOI, and an EOI from the "forwarded and triggered again" state sends a fresh notification. Sources that are built with store-EOI support also accept a store at a second offset as an EOI.

Notifications leave through a valid/ready port that carries the source index. While that port is stalled, each source keeps its own request bit, so no notification is lost. Pending requests are served lowest index first.

Top module: `irq_pq_ctl`

## Requirements
- R1: After reset, every source has P=0 and Q=1 (masked), `notif_valid` is low and `rd_valid` is low.
- R2: A load (`bus_sel`=1, `bus_we`=0) raises `rd_valid` for exactly one cycle, one clock after it is sampled. `rd_data` carries the pre-access state with P in bit 1 and Q in bit 0. Bits 63:2 are zero, and `rd_data` is all zero whenever `rd_valid` is low.
- R3: A load at offset 0x800 returns the state and leaves it unchanged.
- R4: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the old state and force PQ to 00, 01, 10 and 11 respectively. Forcing a state never emits a notification.
- R5: A trigger moves PQ 00→10 and emits one notification. It moves 10→11 and leaves 11 at 11, with no notification. A source at 01 ignores triggers.
- R6: A load at offset 0x000 is an EOI. It moves 10→00. It moves 11→10 and emits a new notification. It leaves 00 and 01 unchanged.
- R7: A store at offset 0x400 is an EOI with the same effect as R6, but only for a source whose bit in `STORE_EOI_MASK` is set (default 0x0F, so sources 0–3). For any other source, and for stores at any other offset, a store changes nothing. Stores never raise `rd_valid`.
- R8: A load at any other offset (for example 0x808, or 0x400 as a load), or to a source index at or above `N_SRC`, returns zero and changes no state.
- R9: When a bus access and a trigger reach the same source in the same cycle, the access is applied first and the trigger is applied to the resulting state.
- R10: While `notif_valid` is high and `notif_ready` is low, `notif_valid` and `notif_src` hold. Each pending request is delivered once, lowest source index first.
- R11: Triggers that arrive while P is set add no notification. A source is delivered once per EOI cycle.
- R12: A notification caused at clock edge E appears on `notif_valid` after edge E+1 when the output slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | IDX_W+12 | {source index, page offset} |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | 64 | Load response, old PQ in bits 1:0 |
| trig_in | input | N_SRC | Per-source trigger pulses |
| notif_valid | output | 1 | Notification available |
| notif_ready | input | 1 | Downstream accepts notification |
| notif_src | output | IDX_W | Source index of the notification |

## Verification
A load sampled at edge E has its response visible right after E, and the new state is in place from E onward. A notification that comes from a trigger or an EOI at edge E shows on the output after E+1, and it is consumed at E+2 if `notif_ready` is high. The bench drives all stimulus on falling edges. It reads load responses at the next falling edge and notifications one falling edge later, so every check lands on the first cycle where the result is due. Stall tests hold `notif_ready` low for several cycles and check on each of them that the output holds.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    localparam int OFF_W  = 12;
    localparam int DATA_W = 64;

    localparam logic [OFF_W-1:0] OFF_EOI_LD = 12'h000;
    localparam logic [OFF_W-1:0] OFF_EOI_ST = 12'h400;
    localparam logic [OFF_W-1:0] OFF_GET    = 12'h800;
    localparam logic [OFF_W-1:0] OFF_SET00  = 12'hC00;
    localparam logic [OFF_W-1:0] OFF_SET01  = 12'hD00;
    localparam logic [OFF_W-1:0] OFF_SET10  = 12'hE00;
    localparam logic [OFF_W-1:0] OFF_SET11  = 12'hF00;

    typedef struct packed {
        logic p;   // forwarded, awaiting EOI
        logic q;   // re-triggered while forwarded
    } pq_t;

    localparam pq_t PQ_IDLE   = '{p: 1'b0, q: 1'b0};
    localparam pq_t PQ_MASKED = '{p: 1'b0, q: 1'b1};
    localparam pq_t PQ_SENT   = '{p: 1'b1, q: 1'b0};
    localparam pq_t PQ_AGAIN  = '{p: 1'b1, q: 1'b1};

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GET,
        OP_SET00,
        OP_SET01,
        OP_SET10,
        OP_SET11,
        OP_EOI
    } pq_op_e;

    function automatic pq_t pq_apply_op(pq_t s, pq_op_e op);
        pq_t r;
        case (op)
            OP_SET00: r = PQ_IDLE;
            OP_SET01: r = PQ_MASKED;
            OP_SET10: r = PQ_SENT;
            OP_SET11: r = PQ_AGAIN;
            OP_EOI:   r = (s.p) ? (s.q ? PQ_SENT : PQ_IDLE) : s;
            default:  r = s;
        endcase
        return r;
    endfunction

    function automatic logic pq_op_emits(pq_t s, pq_op_e op);
        return (op == OP_EOI) && (s == PQ_AGAIN);
    endfunction

    function automatic pq_t pq_trig_next(pq_t s);
        pq_t r;
        case (s)
            PQ_IDLE: r = PQ_SENT;
            PQ_SENT: r = PQ_AGAIN;
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter int                N_SRC          = 8,
    parameter int                IDX_W          = $clog2(N_SRC),
    parameter logic [N_SRC-1:0]  STORE_EOI_MASK = '1,
    localparam int               ADDR_W         = IDX_W + OFF_W
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output pq_op_e            op,
    output logic [IDX_W-1:0]  idx,
    output logic              is_load,
    output logic              known
);
    localparam logic [IDX_W:0] SRC_LIM = (IDX_W+1)'(N_SRC);

    logic [OFF_W-1:0] off;
    logic             src_ok;
    logic             st_ok;

    assign off    = addr[OFF_W-1:0];
    assign idx    = addr[ADDR_W-1:OFF_W];
    assign src_ok = ({1'b0, idx} < SRC_LIM);

    always_comb begin
        st_ok = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (idx == IDX_W'(i)) st_ok = STORE_EOI_MASK[i];
        end
    end

    always_comb begin
        op = OP_NONE;
        if (sel && src_ok) begin
            if (we) begin
                if (off == OFF_EOI_ST && st_ok) op = OP_EOI;
            end else begin
                case (off)
                    OFF_EOI_LD: op = OP_EOI;
                    OFF_GET:    op = OP_GET;
                    OFF_SET00:  op = OP_SET00;
                    OFF_SET01:  op = OP_SET01;
                    OFF_SET10:  op = OP_SET10;
                    OFF_SET11:  op = OP_SET11;
                    default:    op = OP_NONE;
                endcase
            end
        end
    end

    assign is_load = sel && !we;
    assign known   = is_load && (op != OP_NONE);

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
    import irq_pq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pq_op_e op,
    input  logic   trig,
    input  logic   grant,
    output pq_t    pq,
    output logic   req
);
    pq_t  pq_q, after_op, pq_d;
    logic req_q, emit;

    always_comb begin
        after_op = pq_apply_op(pq_q, op);
        pq_d     = trig ? pq_trig_next(after_op) : after_op;
        emit     = pq_op_emits(pq_q, op) || (trig && after_op == PQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq_q  <= PQ_MASKED;
            req_q <= 1'b0;
        end else begin
            pq_q  <= pq_d;
            req_q <= (req_q && !grant) || emit;
        end
    end

    assign pq  = pq_q;
    assign req = req_q;

endmodule

// File: rtl/irq_pq_notify.sv
module irq_pq_notify #(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] grant,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_idx
);
    logic             valid_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pick;
    logic             any_req;
    logic             slot_free;

    always_comb begin
        pick = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) pick = IDX_W'(i);
        end
    end

    assign any_req   = |req;
    assign slot_free = !valid_q || out_ready;

    always_comb begin
        grant = '0;
        if (slot_free && any_req) grant[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (slot_free) begin
            valid_q <= any_req;
            if (any_req) idx_q <= pick;
        end
    end

    assign out_valid = valid_q;
    assign out_idx   = idx_q;

endmodule

// File: rtl/irq_pq_ctl.sv
module irq_pq_ctl
    import irq_pq_pkg::*;
#(
    parameter int                N_SRC          = 8,
    parameter logic [N_SRC-1:0]  STORE_EOI_MASK = N_SRC'(8'h0F),
    localparam int               IDX_W          = $clog2(N_SRC),
    localparam int               ADDR_W         = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SRC-1:0]  trig_in,
    output logic              notif_valid,
    input  logic              notif_ready,
    output logic [IDX_W-1:0]  notif_src
);
    pq_op_e                  op;
    logic [IDX_W-1:0]        idx;
    logic                    is_load;
    logic                    known;
    logic [N_SRC-1:0]        req_vec;
    logic [N_SRC-1:0]        grant_vec;
    logic [N_SRC-1:0][1:0]   pq_vec;
    pq_t                     old_pq;
    logic                    rd_valid_q;
    logic [DATA_W-1:0]       rd_data_q;

    irq_pq_decode #(
        .N_SRC          (N_SRC),
        .IDX_W          (IDX_W),
        .STORE_EOI_MASK (STORE_EOI_MASK)
    ) u_decode (
        .sel     (bus_sel),
        .we      (bus_we),
        .addr    (bus_addr),
        .op      (op),
        .idx     (idx),
        .is_load (is_load),
        .known   (known)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        pq_op_e cell_op;
        pq_t    cell_pq;
        assign cell_op = (idx == IDX_W'(i)) ? op : OP_NONE;

        irq_pq_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .op    (cell_op),
            .trig  (trig_in[i]),
            .grant (grant_vec[i]),
            .pq    (cell_pq),
            .req   (req_vec[i])
        );
        assign pq_vec[i] = cell_pq;
    end

    irq_pq_notify #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_notify (
        .clk       (clk),
        .rst       (rst),
        .req       (req_vec),
        .grant     (grant_vec),
        .out_valid (notif_valid),
        .out_ready (notif_ready),
        .out_idx   (notif_src)
    );

    always_comb begin
        old_pq = PQ_IDLE;
        for (int i = 0; i < N_SRC; i++) begin
            if (idx == IDX_W'(i)) old_pq = pq_vec[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= is_load;
            rd_data_q  <= known ? {{(DATA_W-2){1'b0}}, old_pq} : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

endmodule

// File: rtl/irq_pq_chk.sv
module irq_pq_chk
    import irq_pq_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int IDX_W  = $clog2(N_SRC),
    localparam int ADDR_W = IDX_W + OFF_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  rd_valid,
    input logic [DATA_W-1:0]     rd_data,
    input logic [N_SRC-1:0]      trig_in,
    input logic                  notif_valid,
    input logic                  notif_ready,
    input logic [IDX_W-1:0]      notif_src,
    input logic [N_SRC-1:0][1:0] pq_vec
);
    logic             ld;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    assign ld    = bus_sel && !bus_we;
    assign a_idx = bus_addr[ADDR_W-1:OFF_W];
    assign a_off = bus_addr[OFF_W-1:0];

    assert_rd_follows_load_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> rd_valid);
    assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !ld |=> !rd_valid);
    assert_rd_zero_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);
    assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[DATA_W-1:2] == '0);
    assert_get_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (ld && a_off == OFF_GET && trig_in == '0) |=> $stable(pq_vec));
    assert_notif_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (notif_valid && !notif_ready) |=> (notif_valid && $stable(notif_src)));

    for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
        assert_masked_stays_R5: assert property (@(posedge clk) disable iff (rst)
            (!bus_sel && pq_vec[i] == 2'b01) |=> pq_vec[i] == 2'b01);
        assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (rst)
            (ld && a_off == OFF_EOI_LD && a_idx == IDX_W'(i)
             && pq_vec[i] == 2'b10 && !trig_in[i]) |=> pq_vec[i] == 2'b00);
    end

endmodule

bind irq_pq_ctl irq_pq_chk #(
    .N_SRC (N_SRC),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .trig_in     (trig_in),
    .notif_valid (notif_valid),
    .notif_ready (notif_ready),
    .notif_src   (notif_src),
    .pq_vec      (pq_vec)
);

// File: tb/irq_pq_ctl_bench.sv
module irq_pq_ctl_bench;
    localparam int N    = 8;
    localparam int IW   = 3;
    localparam int AW   = IW + 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic [N-1:0]  trig_in = '0;
    logic          notif_valid;
    logic          notif_ready = 1'b1;
    logic [IW-1:0] notif_src;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    irq_pq_ctl u_irq_pq_ctl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .trig_in(trig_in), .notif_valid(notif_valid),
        .notif_ready(notif_ready), .notif_src(notif_src)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  src;
        logic [11:0] off;
        logic        exp_v;
        logic [1:0]  exp_d;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd2, 12'h800, 1'b1, 2'b01},  // R3 R1 reset value
        '{1'b0, 3'd2, 12'hC00, 1'b1, 2'b01},  // R4 -> 00
        '{1'b0, 3'd2, 12'h800, 1'b1, 2'b00},  // R4
        '{1'b0, 3'd2, 12'hF00, 1'b1, 2'b00},  // R4 -> 11
        '{1'b0, 3'd2, 12'hD00, 1'b1, 2'b11},  // R4 -> 01
        '{1'b0, 3'd2, 12'hE00, 1'b1, 2'b01},  // R4 -> 10
        '{1'b0, 3'd2, 12'h800, 1'b1, 2'b10},  // R3
        '{1'b0, 3'd2, 12'h000, 1'b1, 2'b10},  // R6 -> 00
        '{1'b0, 3'd2, 12'h000, 1'b1, 2'b00},  // R6 stays 00
        '{1'b0, 3'd2, 12'h800, 1'b1, 2'b00},  // R3
        '{1'b0, 3'd2, 12'h808, 1'b1, 2'b00},  // R8 unknown offset
        '{1'b0, 3'd2, 12'h400, 1'b1, 2'b00},  // R8 load at store offset
        '{1'b0, 3'd2, 12'hE00, 1'b1, 2'b00},  // R4 -> 10
        '{1'b1, 3'd2, 12'h400, 1'b0, 2'b00},  // R7 store EOI -> 00
        '{1'b0, 3'd2, 12'h800, 1'b1, 2'b00},  // R7
        '{1'b0, 3'd5, 12'hE00, 1'b1, 2'b01},  // R4 -> 10
        '{1'b1, 3'd5, 12'h400, 1'b0, 2'b00},  // R7 not supported
        '{1'b0, 3'd5, 12'h800, 1'b1, 2'b10},  // R7 unchanged
        '{1'b1, 3'd5, 12'h800, 1'b0, 2'b00},  // R7 store elsewhere
        '{1'b0, 3'd5, 12'h000, 1'b1, 2'b10}   // R6 -> 00
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(logic we, int src, logic [11:0] off, logic [N-1:0] trg);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_we   = we;
        bus_addr = {src[IW-1:0], off};
        trig_in  = trg;
        @(negedge clk);
        bus_sel  = 1'b0;
        bus_we   = 1'b0;
        trig_in  = '0;
    endtask

    task automatic load_chk(string req, int src, logic [11:0] off, logic [1:0] exp);
        access(1'b0, src, off, '0);
        check(req, {63'd0, rd_valid}, 64'd1);
        check(req, rd_data, {62'd0, exp});
    endtask

    task automatic pulse(logic [N-1:0] trg);
        @(negedge clk);
        trig_in = trg;
        @(negedge clk);
        trig_in = '0;
    endtask

    task automatic notif_chk(string req, logic v, int src);
        check(req, {63'd0, notif_valid}, {63'd0, v});
        if (v) check(req, {61'd0, notif_src}, 64'(src));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        notif_chk("R1", 1'b0, 0);
        check("R1", {63'd0, rd_valid}, 64'd0);
        load_chk("R1", 7, 12'h800, 2'b01);

        // Table walk: R2 R3 R4 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            access(TBL[k].we, int'(TBL[k].src), TBL[k].off, '0);
            check("R2", {63'd0, rd_valid}, {63'd0, TBL[k].exp_v});
            check("R2", rd_data, {62'd0, TBL[k].exp_d});
        end

        // R5 masked source ignores trigger
        pulse(8'h01);
        @(negedge clk);
        notif_chk("R5", 1'b0, 0);
        load_chk("R5", 0, 12'h800, 2'b01);

        // R12 R5 trigger from idle notifies after one more edge
        load_chk("R4", 0, 12'hC00, 2'b01);
        pulse(8'h01);
        notif_chk("R12", 1'b0, 0);
        @(negedge clk);
        notif_chk("R12", 1'b1, 0);
        @(negedge clk);
        notif_chk("R10", 1'b0, 0);
        load_chk("R5", 0, 12'h800, 2'b10);

        // R11 repeated triggers coalesce
        pulse(8'h01);
        pulse(8'h01);
        @(negedge clk);
        notif_chk("R11", 1'b0, 0);
        load_chk("R11", 0, 12'h800, 2'b11);

        // R6 EOI from 11 re-notifies
        load_chk("R6", 0, 12'h000, 2'b11);
        @(negedge clk);
        notif_chk("R6", 1'b1, 0);
        @(negedge clk);
        notif_chk("R6", 1'b0, 0);
        load_chk("R6", 0, 12'h800, 2'b10);
        load_chk("R6", 0, 12'h000, 2'b10);
        @(negedge clk);
        notif_chk("R6", 1'b0, 0);
        load_chk("R6", 0, 12'h800, 2'b00);

        // R10 stall: hold, keep pending, lowest index first
        notif_ready = 1'b0;
        load_chk("R4", 1, 12'hC00, 2'b01);
        load_chk("R4", 3, 12'hC00, 2'b01);
        pulse(8'h0A);
        @(negedge clk);
        notif_chk("R10", 1'b1, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            notif_chk("R10", 1'b1, 1);
        end
        pulse(8'h02);
        notif_chk("R10", 1'b1, 1);
        notif_ready = 1'b1;
        @(negedge clk);
        notif_chk("R10", 1'b1, 3);
        @(negedge clk);
        notif_chk("R11", 1'b0, 0);
        load_chk("R11", 1, 12'h800, 2'b11);

        // R9 access and trigger in the same cycle
        access(1'b0, 4, 12'hC00, 8'h10);
        check("R9", rd_data, 64'd1);
        @(negedge clk);
        notif_chk("R9", 1'b1, 4);
        @(negedge clk);
        notif_chk("R9", 1'b0, 0);
        load_chk("R9", 4, 12'h800, 2'b10);
        access(1'b0, 4, 12'h000, 8'h10);
        check("R9", rd_data, 64'd2);
        @(negedge clk);
        notif_chk("R9", 1'b1, 4);
        @(negedge clk);
        notif_chk("R9", 1'b0, 0);
        load_chk("R9", 4, 12'h800, 2'b10);

        summary();
        $finish;
    end

endmodule